// File: doc/BRIEF.md
# Scalar-to-Vector Broadcast Unit

This block decodes and executes a single instruction from a 32-bit word. The instruction copies the value of a general-purpose register into every lane of a vector register. The vector is either 64 or 128 bits wide. The lane width is 8, 16, 32 or 64 bits, chosen by the lowest set bit of a 5-bit immediate field.

The unit drives a source index to an external general-purpose register file, which returns the 64-bit read data combinationally in the same cycle. One cycle after a valid word is presented, the unit produces one of three results:
- a single-cycle vector write (index, 128-bit data, enable);
- an undefined-encoding flag, with no write;
- silence, when the word is some other instruction, so that a neighbouring decoder can claim it.

Top module: `bcast_unit`

## Requirements
- R1: A word is claimed only when bit 31 is 0, bits 29..21 equal 0_0111_0000 and bits 15..10 equal 000011. A valid word that does not match asserts neither `vec_we` nor `insn_undef`. Field positions are: bit 30 is the width bit Q, bits 20..16 are the immediate, bits 9..5 are the source index and bits 4..0 are the destination index.
- R2: A claimed word whose immediate bits 3..0 are all zero raises `insn_undef` and does not write.
- R3: A claimed word with immediate bits 3..0 equal to 1000 and Q = 0 raises `insn_undef` and does not write.
- R4: The lane width is 8 << k, where k is the position of the lowest set bit among immediate bits 3..0. The patterns xxx1, xx10, x100 and 1000 give 8, 16, 32 and 64 bits.
- R5: Immediate bits above the lowest set bit, including bit 4, have no effect on the written data.
- R6: Q = 0 gives a 64-bit vector and writes zeros to bits 127..64. Q = 1 gives a 128-bit vector.
- R7: `gpr_rd_idx` carries the source index. A source index of 31 selects a zero element, whatever the read data is.
- R8: The element is the low lane-width bits of the source value, and it is copied into every lane from lane 0 upward.
- R9: Results appear exactly one clock after the valid word is presented. `vec_we` is a one-cycle pulse, `vec_wr_idx` equals the destination index, and the latency does not depend on data values. No output is raised in a cycle that follows one without a valid word.
- R10: `vec_we` and `insn_undef` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Instruction word |
| gpr_rd_idx | output | 5 | Source register read index |
| gpr_rd_data | input | 64 | Source register read data (same cycle) |
| vec_we | output | 1 | Vector write enable, one-cycle pulse |
| vec_wr_idx | output | 5 | Vector destination index |
| vec_wr_data | output | 128 | Vector write data |
| insn_undef | output | 1 | Undefined encoding flag |

## Verification
A wrong lane-width decode shows up, on the very next clock, as a repeat period in `vec_wr_data` that does not match the one implied by the immediate. A broken zero-register or upper-half mask leaves non-zero bits in positions that must be clear, in that same write. A faulty opcode or undefined-encoding decision shows up one cycle after the strobe, as a write where a flag was due, a flag where silence was due, or both outputs raised at once. Because nothing persists between instructions, any fault is visible in the cycle right after the word that triggers it.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

    localparam int XLEN    = 64;
    localparam int VLEN    = 128;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 5;
    localparam int N_SIZES = 4;
    localparam logic [RIDX_W-1:0] ZERO_REG = 5'd31;

    localparam logic [8:0] OPC_MID = 9'b0_0111_0000;
    localparam logic [5:0] OPC_LOW = 6'b000011;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_e;

    typedef struct packed {
        logic              hit;
        logic              undef;
        logic              wide;
        esize_e            esz;
        logic [RIDX_W-1:0] src;
        logic [RIDX_W-1:0] dst;
    } dec_t;

    typedef struct packed {
        logic              we;
        logic              undef;
        logic              wide;
        logic [RIDX_W-1:0] idx;
        logic [VLEN-1:0]   data;
    } vwr_t;

    function automatic logic opcode_hit(input logic [31:0] w);
        return (w[31] == 1'b0) && (w[29:21] == OPC_MID) && (w[15:10] == OPC_LOW);
    endfunction

    function automatic esize_e lowest_set(input logic [3:0] imm);
        esize_e r;
        casez (imm)
            4'b???1: r = ESZ_8;
            4'b??10: r = ESZ_16;
            4'b?100: r = ESZ_32;
            default: r = ESZ_64;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
    import bcast_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    logic [IMM_W-1:0] imm;
    logic             no_size;
    logic             d_in_half;

    always_comb begin
        imm       = word[20:16];
        no_size   = (imm[3:0] == 4'b0000);
        d_in_half = (imm[3:0] == 4'b1000) && !word[30];

        dec.hit   = opcode_hit(word);
        dec.undef = no_size || d_in_half;
        dec.wide  = word[30];
        dec.esz   = lowest_set(imm[3:0]);
        dec.src   = word[9:5];
        dec.dst   = word[4:0];
    end
endmodule

// File: rtl/bcast_replicate.sv
module bcast_replicate
    import bcast_pkg::*;
#(
    parameter int SRC_W = XLEN,
    parameter int VEC_W = VLEN
) (
    input  logic [SRC_W-1:0] src,
    input  logic             zero_src,
    input  esize_e           esz,
    input  logic             wide,
    output logic [VEC_W-1:0] vec
);
    localparam int HALF_W = VEC_W / 2;

    logic [SRC_W-1:0]              elem;
    logic [N_SIZES-1:0][VEC_W-1:0] cand;
    logic [VEC_W-1:0]              full;

    assign elem = zero_src ? '0 : src;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int EW = 8 << s;
        localparam int NL = VEC_W / EW;
        assign cand[s] = {NL{elem[EW-1:0]}};
    end

    always_comb begin
        full = cand[esz];
        vec  = wide ? full : {{HALF_W{1'b0}}, full[HALF_W-1:0]};
    end
endmodule

// File: rtl/bcast_unit.sv
module bcast_unit
    import bcast_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                insn_valid,
    input  logic [31:0]         insn_word,
    output logic [RIDX_W-1:0]   gpr_rd_idx,
    input  logic [XLEN-1:0]     gpr_rd_data,
    output logic                vec_we,
    output logic [RIDX_W-1:0]   vec_wr_idx,
    output logic [VLEN-1:0]     vec_wr_data,
    output logic                insn_undef
);
    dec_t            dec;
    logic [VLEN-1:0] bvec;
    vwr_t            wr_q;

    bcast_decode u_dec (
        .word (insn_word),
        .dec  (dec)
    );

    assign gpr_rd_idx = dec.src;

    bcast_replicate #(.SRC_W(XLEN), .VEC_W(VLEN)) u_rep (
        .src      (gpr_rd_data),
        .zero_src (dec.src == ZERO_REG),
        .esz      (dec.esz),
        .wide     (dec.wide),
        .vec      (bvec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
        end else begin
            wr_q.we    <= insn_valid && dec.hit && !dec.undef;
            wr_q.undef <= insn_valid && dec.hit && dec.undef;
            if (insn_valid) begin
                wr_q.wide <= dec.wide;
                wr_q.idx  <= dec.dst;
                wr_q.data <= bvec;
            end
        end
    end

    assign vec_we      = wr_q.we;
    assign insn_undef  = wr_q.undef;
    assign vec_wr_idx  = wr_q.idx;
    assign vec_wr_data = wr_q.data;

    // R10
    we_undef_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(vec_we && insn_undef));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> (!vec_we && !insn_undef));

    // R1
    nohit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && (insn_word[31] || insn_word[15:10] != 6'b000011)) |=> (!vec_we && !insn_undef));

    // R2
    undef_nosize_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && opcode_hit(insn_word) && insn_word[19:16] == 4'b0000) |=> (insn_undef && !vec_we));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_we && !wr_q.wide) |-> (vec_wr_data[VLEN-1:XLEN] == '0));

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && insn_word[9:5] == ZERO_REG) |=> (!vec_we || vec_wr_data == '0));

    // R9
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_we |=> (!vec_we || $past(insn_valid)));
endmodule

// File: tb/bcast_unit_tb.sv
module bcast_unit_tb;
    import bcast_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn_word = '0;
    logic [4:0]   gpr_rd_idx;
    logic [63:0]  gpr_rd_data;
    logic         vec_we;
    logic [4:0]   vec_wr_idx;
    logic [127:0] vec_wr_data;
    logic         insn_undef;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    function automatic logic [63:0] gpr_val(input logic [4:0] i);
        return 64'h8877_6655_4433_2211 ^ {8{3'b101, i}} ^ ({59'd0, i} << 37);
    endfunction

    assign gpr_rd_data = (gpr_rd_idx == 5'd31) ? 64'hFFFF_FFFF_FFFF_FFFF : gpr_val(gpr_rd_idx);

    bcast_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .insn_valid  (insn_valid),
        .insn_word   (insn_word),
        .gpr_rd_idx  (gpr_rd_idx),
        .gpr_rd_data (gpr_rd_data),
        .vec_we      (vec_we),
        .vec_wr_idx  (vec_wr_idx),
        .vec_wr_data (vec_wr_data),
        .insn_undef  (insn_undef)
    );

    function automatic logic [31:0] mk(input logic q, input logic [4:0] imm,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {1'b0, q, 9'b0_0111_0000, imm, 6'b000011, rn, rd};
    endfunction

    function automatic logic model_undef(input logic q, input logic [4:0] imm);
        return (imm[3:0] == 4'd0) || (imm[3:0] == 4'b1000 && !q);
    endfunction

    function automatic logic [127:0] model_data(input logic q, input logic [4:0] imm,
                                                input logic [4:0] rn);
        logic [63:0]  src;
        logic [127:0] d;
        int sz;
        int ew;
        int vw;
        sz  = 3;
        for (int i = 3; i >= 0; i--) if (imm[i]) sz = i;
        ew  = 8 << sz;
        vw  = q ? 128 : 64;
        src = (rn == 5'd31) ? 64'd0 : gpr_val(rn);
        d   = '0;
        for (int b = 0; b < 128; b++) if (b < vw) d[b] = src[b % ew];
        return d;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; outputs are registered at the next rising edge
    // and sampled at the falling edge after it.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = w;
        #1;
        chk("R7 read index", {123'd0, gpr_rd_idx}, {123'd0, w[9:5]});
        @(negedge clk);
        insn_valid = 1'b0;
        insn_word  = 32'hFFFF_FFFF;
    endtask

    // q, imm5, rn, rd
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 5'b00001, 5'd3,  5'd1},
        {1'b0, 5'b00001, 5'd4,  5'd2},
        {1'b1, 5'b00010, 5'd5,  5'd7},
        {1'b0, 5'b11110, 5'd6,  5'd8},
        {1'b1, 5'b00100, 5'd7,  5'd9},
        {1'b0, 5'b10100, 5'd8,  5'd10},
        {1'b1, 5'b01000, 5'd9,  5'd11},
        {1'b1, 5'b11000, 5'd10, 5'd12},
        {1'b0, 5'b01000, 5'd11, 5'd13},
        {1'b1, 5'b00000, 5'd12, 5'd14},
        {1'b0, 5'b10000, 5'd13, 5'd15},
        {1'b1, 5'b00001, 5'd31, 5'd16},
        {1'b0, 5'b11111, 5'd31, 5'd31}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset we", {127'd0, vec_we}, 128'd0);
        chk("R9 reset undef", {127'd0, insn_undef}, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic q;
            logic [4:0] imm;
            logic [4:0] rn;
            logic [4:0] rd;
            logic eu;
            {q, imm, rn, rd} = VEC[k];
            eu = model_undef(q, imm);
            issue(mk(q, imm, rn, rd));
            chk("R2/R3 undef flag", {127'd0, insn_undef}, {127'd0, eu});
            chk("R10 write enable", {127'd0, vec_we}, {127'd0, !eu});
            if (!eu) begin
                chk("R4/R5/R6/R8 data", vec_wr_data, model_data(q, imm, rn));
                chk("R9 dest index", {123'd0, vec_wr_idx}, {123'd0, rd});
            end
            @(negedge clk);
            chk("R9 single pulse", {126'd0, vec_we, insn_undef}, 128'd0);
        end

        // R1: words that differ from the opcode in one fixed bit
        issue(mk(1'b1, 5'b00001, 5'd3, 5'd1) | 32'h8000_0000);
        chk("R1 bit31 set", {126'd0, vec_we, insn_undef}, 128'd0);
        issue(mk(1'b1, 5'b00000, 5'd3, 5'd1) ^ 32'h0000_0400);
        chk("R1 bit10 clear", {126'd0, vec_we, insn_undef}, 128'd0);
        issue(mk(1'b0, 5'b00001, 5'd3, 5'd1) ^ 32'h0020_0000);
        chk("R1 bit21 set", {126'd0, vec_we, insn_undef}, 128'd0);

        // R5: every bit above the lowest set one toggled, same data
        issue(mk(1'b1, 5'b11111, 5'd20, 5'd3));
        chk("R5 upper imm ignored", vec_wr_data, model_data(1'b1, 5'b00001, 5'd20));

        // R9: an opcode word without the strobe does nothing
        @(negedge clk);
        insn_word = mk(1'b1, 5'b00001, 5'd3, 5'd1);
        @(negedge clk);
        chk("R9 no strobe", {126'd0, vec_we, insn_undef}, 128'd0);

        // R2 then R8 back-to-back
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = mk(1'b1, 5'b10000, 5'd2, 5'd4);
        @(negedge clk);
        chk("R2 back-to-back undef", {126'd0, vec_we, insn_undef}, 128'd1);
        insn_word  = mk(1'b1, 5'b00010, 5'd2, 5'd4);
        @(negedge clk);
        insn_valid = 1'b0;
        chk("R8 back-to-back write", vec_wr_data, model_data(1'b1, 5'b00010, 5'd2));
        chk("R10 back-to-back flags", {126'd0, vec_we, insn_undef}, 128'd2);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule